// File: doc/BRIEF.md
# HDLC Receive Byte Queue with Frame Tags

This block sits between an HDLC deframer and a processor read port. Each byte the deframer delivers is stored with a 2-bit tag. The tag says where the byte falls in its frame and, for a closing byte, whether the frame check passed. The processor sees the oldest stored byte and its tag at all times. Pulsing the read strobe removes that byte.

A status byte reports the head tag and a coarse fill level. The fill level is deliberately slow. After any accepted write or read it holds its old value until a set number of serial bit-clock falling edges have arrived with no further access. That number is two in normal mode and four in quad mode. Falling edges arrive as one-cycle pulses that are synchronous to the system clock. A write into a full queue is discarded and sets a sticky overflow flag.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset the queue is empty, `status` is 0x00, `rd_data` is 0x00 and `overflow` is 0.
- R2: `rd_data` presents the oldest stored byte with every bit in the position it was written (bit 0 stays bit 0), and a `pop` pulse removes that byte, so bytes leave in write order.
- R3: `status[7:6]` gives the tag of the head byte: 00 middle byte, 01 first byte, 10 last byte with good check, 11 last byte with bad check; `status[3:0]` is always 0.
- R4: `status[5:4]` reports the fill level with DEPTH=19: 00 empty, 01 for 1 to 14 bytes, 11 for 15 to 18 bytes, 10 for exactly 19 (full).
- R5: After an accepted push or pop, `status[5:4]` keeps its value until the second `ser_fall` pulse with no access in between, and it takes the new level on the clock edge that samples that pulse.
- R6: With `quad_mode` high when the access happens, the update waits for four `ser_fall` pulses instead of two.
- R7: A push while 19 bytes are stored is discarded and sets `overflow`. The flag stays set until `ovf_clr` is pulsed, and a new overflow in the same cycle wins over the clear.
- R8: A pop while empty has no effect: `rd_data` reads 0x00, the tag reads 00, and the stored contents and fill level are unchanged.
- R9: An accepted access that arrives while an update is still pending restarts the edge count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quad_mode | input | 1 | Wait for four serial edges instead of two |
| ser_fall | input | 1 | One-cycle pulse per serial bit-clock falling edge |
| push | input | 1 | Write strobe from the deframer |
| push_data | input | 8 | Received byte, first serial bit in bit 0 |
| push_tag | input | 2 | Frame position / check outcome tag |
| pop | input | 1 | Read strobe from the processor port |
| rd_data | output | 8 | Oldest stored byte, 0x00 when empty |
| status | output | 8 | {head tag, fill level, 4'b0} |
| overflow | output | 1 | Sticky dropped-write flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
A wrong pointer or occupancy count shows up on `rd_data` and in the head tag at the next read. The bench catches it the first time a queued byte is compared. An error in the edge counter only becomes visible at the band boundaries (empty, 14/15 and full). For that reason the bench probes the level one edge before and one edge after the expected update, in both modes, and again after a restarting access. A lost overflow or a lost drop shows up when the full queue is drained: it yields exactly nineteen bytes in order.

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH     = 19,
  parameter int HIGH_MARK = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       quad_mode,
  input  logic       ser_fall,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic [1:0] push_tag,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic [7:0] status,
  output logic       overflow,
  input  logic       ovf_clr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [9:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [2:0]    wait_cnt;
  logic [1:0]    band;

  wire empty   = (cnt == '0);
  wire full    = (cnt == CW'(DEPTH));
  wire do_push = push && !full;
  wire do_pop  = pop && !empty;
  wire access  = do_push || do_pop;

  function automatic logic [1:0] band_of(input logic [CW-1:0] c);
    if (c == '0)                    return 2'b00;
    else if (c == CW'(DEPTH))       return 2'b10;
    else if (c >= CW'(HIGH_MARK))   return 2'b11;
    else                            return 2'b01;
  endfunction

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= {push_tag, push_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      wait_cnt <= '0;
      band     <= 2'b00;
      overflow <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (access)
        wait_cnt <= quad_mode ? 3'd4 : 3'd2;
      else if (ser_fall && wait_cnt != '0)
        wait_cnt <= wait_cnt - 1'b1;
      if (!access && ser_fall && wait_cnt == 3'd1)
        band <= band_of(cnt);
      if (push && full)
        overflow <= 1'b1;
      else if (ovf_clr)
        overflow <= 1'b0;
    end
  end

  wire [9:0] head = mem[rp];
  assign rd_data = empty ? 8'h00 : head[7:0];
  assign status  = {(empty ? 2'b00 : head[9:8]), band, 4'b0000};

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_band_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> $stable(band));
  p_band_needs_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band) |-> $past(ser_fall));
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !ovf_clr) |=> overflow);
  p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (full && overflow));
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && $stable(band)));
endmodule

// File: tb/test_hdlc_rx_fifo.sv
module test_hdlc_rx_fifo;
  logic clk = 0, rst_n = 0, quad_mode = 0, ser_fall = 0, push = 0, pop = 0, ovf_clr = 0;
  logic [7:0] push_data = 0;
  logic [1:0] push_tag = 0;
  logic [7:0] rd_data, status;
  logic overflow;
  int errors = 0, checks = 0, cycles = 0;
  logic [9:0] q[$];

  always #2 clk = ~clk;

  hdlc_rx_fifo i_hdlc_rx_fifo (.clk, .rst_n, .quad_mode, .ser_fall, .push, .push_data,
    .push_tag, .pop, .rd_data, .status, .overflow, .ovf_clr);

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive_push(input logic [1:0] tag, input logic [7:0] d);
    @(negedge clk);
    push = 1; push_tag = tag; push_data = d;
    if (q.size() < 19) q.push_back({tag, d});
    @(negedge clk);
    push = 0;
  endtask

  task automatic monitor_pop(input string req);
    logic [9:0] e;
    @(negedge clk);
    e = (q.size() > 0) ? q.pop_front() : 10'h000;
    chk({req, " data"}, rd_data, e[7:0]);
    chk({req, " tag"}, status[7:6], e[9:8]);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  task automatic falls(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser_fall = 1;
      @(negedge clk); ser_fall = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 overflow", overflow, 0);

    drive_push(2'b01, 8'hA5);
    chk("R5 no immediate update", status[5:4], 2'b00);
    falls(1);
    chk("R5 one edge holds", status[5:4], 2'b00);
    falls(1);
    chk("R4 band 1..14", status[5:4], 2'b01);
    chk("R3 head tag first", status[7:6], 2'b01);
    chk("R2 head data bit order", rd_data, 8'hA5);
    chk("R3 low nibble zero", status[3:0], 0);

    for (int i = 1; i < 14; i++) drive_push(2'b00, 8'(i * 13 + 5));
    falls(2);
    chk("R4 14 bytes", status[5:4], 2'b01);
    drive_push(2'b00, 8'h15);
    falls(1);
    drive_push(2'b00, 8'h16);
    falls(1);
    chk("R9 restart holds", status[5:4], 2'b01);
    falls(1);
    chk("R9 update after restart", status[5:4], 2'b11);
    drive_push(2'b00, 8'h17);
    drive_push(2'b11, 8'h18);
    falls(2);
    chk("R4 18 bytes", status[5:4], 2'b11);
    drive_push(2'b10, 8'h19);
    falls(2);
    chk("R4 full", status[5:4], 2'b10);
    chk("R7 no overflow yet", overflow, 0);
    drive_push(2'b01, 8'hEE);
    chk("R7 overflow set", overflow, 1);
    falls(2);
    chk("R7 still full", status[5:4], 2'b10);
    chk("R7 sticky", overflow, 1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk("R7 clear", overflow, 0);

    for (int i = 0; i < 19; i++) monitor_pop("R2 R3 drain");
    falls(2);
    chk("R4 empty after drain", status[5:4], 2'b00);

    monitor_pop("R8 empty pop");
    falls(2);
    chk("R8 band unchanged", status[5:4], 2'b00);
    chk("R8 rd_data", rd_data, 0);

    quad_mode = 1;
    drive_push(2'b10, 8'h81);
    falls(2);
    chk("R6 two edges hold", status[5:4], 2'b00);
    falls(1);
    chk("R6 three edges hold", status[5:4], 2'b00);
    falls(1);
    chk("R6 four edges update", status[5:4], 2'b01);
    chk("R3 tag last good", status[7:6], 2'b10);
    drive_push(2'b11, 8'h7E);
    monitor_pop("R2 quad first");
    monitor_pop("R3 quad bad tag");
    monitor_pop("R8 empty after quad");
    drive_push(2'b00, 8'h42);
    monitor_pop("R8 state intact");
    falls(4);
    chk("R6 empty after quad", status[5:4], 2'b00);
    summary();
  end
endmodule